// File: doc/BRIEF.md
# Privilege Mode and Exception Controller

This controller holds the running mode of one execution engine and decides where control goes when an exception is taken or when a handler returns. There are three modes on two privilege levels. User mode is unprivileged. Supervisor mode and fault mode are privileged. An exception taken from user mode enters supervisor mode. Any exception raised while in supervisor mode is a double fault and enters fault mode. This includes debug events, which are handled in fault mode and return to supervisor mode afterwards.

Six request lines come in. Four are synchronous: supervisor call, data fault (from a fetch, load or store), timer tick and debug. Two are asynchronous: management console and I/O. A flag marks an attempt to run a privileged operation. In user mode that attempt becomes an illegal-operation exception of its own. When several requests arrive in the same cycle, the controller picks one by fixed priority. It reports that request as a 3-bit cause code with a take pulse in the same cycle, and the mode changes on the next clock edge.

A one-entry saved-mode register records the mode to restore when a handler returns. Handler addresses, program-counter saving and the timer itself belong to other blocks.

Top module: `pmx_ctrl`

## Requirements
- R1: `mode_o` encodes user as 0, supervisor as 1 and fault as 2. `priv_o` is 1 exactly when the mode is supervisor or fault.
- R2: While reset is held, and after it is released, the mode is supervisor and the saved mode is user. A return made straight after reset therefore enters user mode.
- R3: An exception taken in user mode makes the mode supervisor on the next clock edge.
- R4: An exception taken in supervisor mode makes the mode fault on the next edge, whatever the cause, debug included.
- R5: When a return is made with no exception taken in the same cycle, fault mode goes to supervisor mode and supervisor mode goes to the saved mode. After a fault-to-supervisor return the saved mode is user. A return made in user mode has no effect.
- R6: `take_o` is high in the same cycle as any accepted request. `cause_o` then gives the accepted request: supervisor call 0, data fault 1, timer tick 2, debug 3, console 4, I/O 5, illegal operation 6. When nothing is taken, `cause_o` is 0.
- R7: Priority from highest to lowest is data fault, illegal operation, supervisor call, debug, timer tick, console, I/O. Every synchronous cause beats every asynchronous one.
- R8: In fault mode, console and I/O requests are ignored. A synchronous exception there is still taken, the mode stays fault, and a later return still goes to supervisor mode.
- R9: `illegal_o` is high exactly when `priv_attempt_i` is high in user mode, and it raises cause 6. A privileged attempt in supervisor or fault mode has no effect.
- R10: When an exception and a return occur in the same cycle, the exception wins and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_svc_i | input | 1 | Supervisor call request |
| req_dfault_i | input | 1 | Data fault request (fetch, load or store) |
| req_tick_i | input | 1 | Periodic timer tick request |
| req_debug_i | input | 1 | Debug request |
| req_console_i | input | 1 | Management console request (asynchronous) |
| req_io_i | input | 1 | I/O request (asynchronous) |
| priv_attempt_i | input | 1 | A privileged operation is being attempted |
| exc_return_i | input | 1 | Return-from-exception strobe |
| mode_o | output | 2 | Current mode (0 user, 1 supervisor, 2 fault) |
| priv_o | output | 1 | Current mode is privileged |
| cause_o | output | 3 | Cause code of the accepted request |
| take_o | output | 1 | An exception is taken this cycle |
| illegal_o | output | 1 | Privileged attempt made in user mode |

## Verification
The assertions check on every cycle that a data fault always wins and carries its own code, and that an asynchronous cause is reported only when no synchronous request is present. They also check that fault mode never reports console or I/O, and that each single-step transition lands where it should: user to supervisor, supervisor to fault, fault-return to supervisor, and a user-mode return that changes nothing. Other behaviour depends on history, and only the bench's scenarios can show it. That covers the saved-mode content after reset, the full path user to supervisor to fault and back down to user, and whether each of the 256 input patterns, applied in each mode, yields the right cause and the right next mode.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

  typedef enum logic [1:0] {
    MODE_USER  = 2'd0,
    MODE_SUPV  = 2'd1,
    MODE_FAULT = 2'd2
  } pmx_mode_e;

  localparam int CAUSE_W = 3;

  localparam logic [CAUSE_W-1:0] CAUSE_SVC     = 3'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_DFAULT  = 3'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_TICK    = 3'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_DEBUG   = 3'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_CONSOLE = 3'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_IO      = 3'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 3'd6;

  // Request slots in priority order, slot 0 highest
  localparam int NUM_SRC = 7;
  localparam int SRC_W   = $clog2(NUM_SRC);

  function automatic logic [CAUSE_W-1:0] slot_to_cause(input logic [SRC_W-1:0] slot);
    logic [CAUSE_W-1:0] c;
    case (slot)
      3'd0:    c = CAUSE_DFAULT;
      3'd1:    c = CAUSE_ILLEGAL;
      3'd2:    c = CAUSE_SVC;
      3'd3:    c = CAUSE_DEBUG;
      3'd4:    c = CAUSE_TICK;
      3'd5:    c = CAUSE_CONSOLE;
      default: c = CAUSE_IO;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pmx_pick.sv
module pmx_pick #(
  parameter int N = 7,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);

  // Lowest index wins
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/pmx_mode_fsm.sv
module pmx_mode_fsm
  import pmx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take_i,
  input  logic      ret_i,
  output pmx_mode_e mode_o
);

  pmx_mode_e mode_q, mode_d;
  pmx_mode_e saved_q, saved_d;
  logic      mode_en, saved_en;

  always_comb begin
    mode_d   = mode_q;
    saved_d  = saved_q;
    mode_en  = 1'b0;
    saved_en = 1'b0;
    if (take_i) begin
      mode_en = 1'b1;
      mode_d  = (mode_q == MODE_USER) ? MODE_SUPV : MODE_FAULT;
      // Re-entry into fault mode keeps the existing saved mode
      if (mode_q != MODE_FAULT) begin
        saved_en = 1'b1;
        saved_d  = mode_q;
      end
    end else if (ret_i && (mode_q != MODE_USER)) begin
      mode_en  = 1'b1;
      mode_d   = saved_q;
      saved_en = 1'b1;
      saved_d  = MODE_USER;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_SUPV;
      saved_q <= MODE_USER;
    end else begin
      if (mode_en)  mode_q  <= mode_d;
      if (saved_en) saved_q <= saved_d;
    end
  end

  assign mode_o = mode_q;

  assert_user_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_USER && take_i) |=> (mode_q == MODE_SUPV));

  assert_double_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SUPV && take_i) |=> (mode_q == MODE_FAULT));

  assert_fault_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FAULT && ret_i && !take_i) |=> (mode_q == MODE_SUPV));

  assert_user_ret_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_USER && ret_i && !take_i) |=> (mode_q == MODE_USER));

  assert_fault_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FAULT && take_i) |=> (mode_q == MODE_FAULT));

endmodule

// File: rtl/pmx_ctrl.sv
module pmx_ctrl
  import pmx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_svc_i,
  input  logic       req_dfault_i,
  input  logic       req_tick_i,
  input  logic       req_debug_i,
  input  logic       req_console_i,
  input  logic       req_io_i,
  input  logic       priv_attempt_i,
  input  logic       exc_return_i,
  output logic [1:0] mode_o,
  output logic       priv_o,
  output logic [2:0] cause_o,
  output logic       take_o,
  output logic       illegal_o
);

  localparam int SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released through a flop chain
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[SYNC_STAGES-1];

  pmx_mode_e           mode;
  logic                async_ok;
  logic [NUM_SRC-1:0]  req_vec;
  logic                pick_valid;
  logic [SRC_W-1:0]    pick_idx;

  assign illegal_o = priv_attempt_i && (mode == MODE_USER);
  assign async_ok  = (mode != MODE_FAULT);

  // Slot order sets the priority, slot 0 first
  assign req_vec = {req_io_i      && async_ok,
                    req_console_i && async_ok,
                    req_tick_i,
                    req_debug_i,
                    req_svc_i,
                    illegal_o,
                    req_dfault_i};

  pmx_pick #(.N(NUM_SRC)) u_pick (
    .req_i   (req_vec),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  assign take_o  = pick_valid;
  assign cause_o = pick_valid ? slot_to_cause(pick_idx) : CAUSE_SVC;

  pmx_mode_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .take_i (pick_valid),
    .ret_i  (exc_return_i),
    .mode_o (mode)
  );

  assign mode_o = mode;
  assign priv_o = (mode != MODE_USER);

  assert_dfault_wins_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_dfault_i |-> (take_o && cause_o == CAUSE_DFAULT));

  assert_sync_over_async_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (take_o && (cause_o == CAUSE_CONSOLE || cause_o == CAUSE_IO)) |->
    !(req_svc_i || req_dfault_i || req_tick_i || req_debug_i || illegal_o));

  assert_async_masked_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_o == 2'd2 && take_o) |-> (cause_o != CAUSE_CONSOLE && cause_o != CAUSE_IO));

  assert_illegal_cause_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (illegal_o && !req_dfault_i) |-> (take_o && cause_o == CAUSE_ILLEGAL));

  assert_priv_mode_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    priv_o |-> (mode_o == 2'd1 || mode_o == 2'd2));

endmodule

// File: tb/tb_pmx_ctrl.sv
module tb_pmx_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_svc_i, req_dfault_i, req_tick_i, req_debug_i;
  logic       req_console_i, req_io_i, priv_attempt_i, exc_return_i;
  logic [1:0] mode_o;
  logic       priv_o, take_o, illegal_o;
  logic [2:0] cause_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  pmx_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_svc_i(req_svc_i), .req_dfault_i(req_dfault_i),
    .req_tick_i(req_tick_i), .req_debug_i(req_debug_i),
    .req_console_i(req_console_i), .req_io_i(req_io_i),
    .priv_attempt_i(priv_attempt_i), .exc_return_i(exc_return_i),
    .mode_o(mode_o), .priv_o(priv_o), .cause_o(cause_o),
    .take_o(take_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bit map: 0 svc, 1 dfault, 2 tick, 3 debug, 4 console, 5 io, 6 priv, 7 return
  task automatic drive(input logic [7:0] p);
    req_svc_i      = p[0];
    req_dfault_i   = p[1];
    req_tick_i     = p[2];
    req_debug_i    = p[3];
    req_console_i  = p[4];
    req_io_i       = p[5];
    priv_attempt_i = p[6];
    exc_return_i   = p[7];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drive(8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // One pattern for one clock, then idle; sampled at the following negedge
  task automatic step(input logic [7:0] p);
    drive(p);
    @(negedge clk);
    drive(8'h00);
  endtask

  task automatic go_mode(input int m);
    do_reset();
    if (m == 0) step(8'h80);
    else if (m == 2) step(8'h01);
  endtask

  // Expected cause (-1 when nothing is taken), from the priority rules of R7, R8 and R9
  function automatic int exp_cause(input int m, input logic [7:0] p);
    bit ill, aok;
    ill = p[6] && (m == 0);
    aok = (m != 2);
    if (p[1])              return 1;
    else if (ill)          return 6;
    else if (p[0])         return 0;
    else if (p[3])         return 3;
    else if (p[2])         return 2;
    else if (p[4] && aok)  return 4;
    else if (p[5] && aok)  return 5;
    return -1;
  endfunction

  function automatic int exp_next(input int m, input logic [7:0] p);
    if (exp_cause(m, p) >= 0) return (m == 0) ? 1 : 2;
    if (p[7]) begin
      if (m == 2) return 1;
      return 0;
    end
    return m;
  endfunction

  initial begin
    rst_n = 1'b0;
    drive(8'h00);
    repeat (2) @(negedge clk);
    chk("R2", "mode in reset", int'(mode_o), 1);
    chk("R1", "priv in reset", int'(priv_o), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "mode after reset", int'(mode_o), 1);
    chk("R6", "idle take", int'(take_o), 0);
    chk("R6", "idle cause", int'(cause_o), 0);

    // Sweep of every input pattern in every mode
    for (int m = 0; m < 3; m++) begin
      for (int pi = 0; pi < 256; pi++) begin
        logic [7:0] p;
        int ec;
        p = 8'(pi);
        go_mode(m);
        chk("R1", "start mode", int'(mode_o), m);
        chk("R1", "priv", int'(priv_o), (m != 0) ? 1 : 0);
        drive(p);
        #1;
        ec = exp_cause(m, p);
        chk("R6", "take", int'(take_o), (ec >= 0) ? 1 : 0);
        if (ec >= 0) chk("R7", "cause", int'(cause_o), ec);
        chk("R9", "illegal", int'(illegal_o), (p[6] && m == 0) ? 1 : 0);
        @(negedge clk);
        drive(8'h00);
        if (m == 0)      chk("R3", "next mode from user", int'(mode_o), exp_next(m, p));
        else if (m == 1) chk("R4", "next mode from supervisor", int'(mode_o), exp_next(m, p));
        else             chk("R8", "next mode from fault", int'(mode_o), exp_next(m, p));
        if (p[7] && ec >= 0) chk("R10", "exception beats return", int'(mode_o), (m == 0) ? 1 : 2);
      end
    end

    // Full path: supervisor -> user -> supervisor -> fault (debug) -> supervisor -> user
    do_reset();
    step(8'h80); chk("R2", "return after reset", int'(mode_o), 0);
    step(8'h01); chk("R3", "svc from user", int'(mode_o), 1);
    step(8'h08); chk("R4", "debug from supervisor", int'(mode_o), 2);
    step(8'h04); chk("R8", "tick re-entry in fault", int'(mode_o), 2);
    step(8'h30); chk("R8", "async masked in fault", int'(mode_o), 2);
    step(8'h80); chk("R5", "debug handler returns", int'(mode_o), 1);
    step(8'h80); chk("R5", "supervisor returns to user", int'(mode_o), 0);
    step(8'h80); chk("R5", "user return ignored", int'(mode_o), 0);
    step(8'h40); chk("R9", "illegal op enters supervisor", int'(mode_o), 1);
    step(8'h40); chk("R9", "privileged op in supervisor", int'(mode_o), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule